// File: doc/BRIEF.md
# Serial debug port mode selector

This block sits on the shared debug clock and the shared mode-select/data line of a chip's debug port. It decides whether that pair of pins serves a JTAG test access port or a two-wire serial debug engine. Out of reset the port works as JTAG. The block moves it to serial-wire operation only after it has seen a fixed switch sequence on the line: a long run of high samples, a 16-bit signature, and then a second long run of high samples.

The line is sampled on every rising edge of the debug clock. The switch needs only the clock pin and the data/mode pin. The block drives a mode flag to the downstream pin steering. It also gives two single-cycle pulses: one when the signature has been recognised and one when the switch takes effect. Once the port has switched, it stays in serial-wire mode until the asynchronous reset. No reverse sequence is recognised.

Top module: `dbg_mode_sel`

## Requirements
- R1: While reset is asserted, and after it is released, `swd_mode_o` is 0 (JTAG), and `sig_hit_o` and `switch_done_o` are 0.
- R2: A leading run counts as valid only when it has at least 51 consecutive high samples. With 50 or fewer high samples before the first low sample, no signature is recognised.
- R3: The signature is 16'h79E7 and is sent most significant bit first. Its first bit (bit 15, value 0) is the first low sample that follows a valid leading run.
- R4: If any of the 16 signature bits does not match, the block abandons the attempt and goes back to looking for a fresh run of high samples. No hit pulse is given.
- R5: `sig_hit_o` is high for exactly one cycle. It rises on the clock edge that samples the last (16th) signature bit, when all 16 bits matched.
- R6: After the signature, 51 further high samples are needed, and the final signature bit does not count toward them. A low sample before the 51st one keeps the mode at JTAG and restarts the search.
- R7: On the edge that samples the 51st trailing high sample, `swd_mode_o` goes to 1 and `switch_done_o` is high for exactly that one cycle.
- R8: Once `swd_mode_o` is 1, it stays 1 whatever the line does, and any further switch sequence gives no pulses. Only the asynchronous reset `rst_ni` returns it to 0, and it does so at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dio_i | input | 1 | Shared data / mode-select line |
| swd_mode_o | output | 1 | 0 = JTAG, 1 = serial-wire debug |
| sig_hit_o | output | 1 | One-cycle pulse when the signature is recognised |
| switch_done_o | output | 1 | One-cycle pulse in the cycle the mode flag changes to 1 |

## Verification
The assertions assume that `dio_i` is stable around each rising edge of `clk_i`, and that reset is asserted from time zero before the first edge, so that every registered value they compare against has a defined history. The bench changes the line only on falling clock edges. It holds reset low over the first edges and releases it on a falling edge, so that each sample is taken cleanly. The mid-run reset is likewise applied away from the rising edge, and the asynchronous clear is observed before any clock edge arrives.

// File: rtl/dbg_sel_pkg.sv
package dbg_sel_pkg;
  localparam int unsigned SIG_W      = 16;
  localparam logic [15:0] SWITCH_SIG = 16'h79E7;
  localparam int unsigned RUN_MIN    = 51;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_SIG,
    ST_TRAIL,
    ST_SWD
  } sel_state_e;
endpackage

// File: rtl/dbg_run_cnt.sv
module dbg_run_cnt #(
  parameter int unsigned RUN_MIN = 51,
  localparam int unsigned CW     = $clog2(RUN_MIN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic run_ok_o,
  output logic near_o
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(RUN_MIN);
  localparam logic [CW-1:0] CNT_NEAR = CW'(RUN_MIN - 1);

  logic [CW-1:0] cnt_q;

  // saturating count of consecutive high samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !line_i)   cnt_q <= '0;
    else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign run_ok_o = (cnt_q == CNT_MAX);
  assign near_o   = (cnt_q == CNT_NEAR);

  assert_run_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_zero_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_i |=> !run_ok_o && !near_o);
  assert_clr_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !run_ok_o);
endmodule

// File: rtl/dbg_sig_match.sv
module dbg_sig_match #(
  parameter int unsigned SIG_W  = 16,
  parameter logic [SIG_W-1:0] SIG = 16'h79E7,
  localparam int unsigned IW    = $clog2(SIG_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic exp_bit_o,
  output logic last_o
);
  localparam logic [IW-1:0] IDX_START = IW'(SIG_W - 2);

  logic [IW-1:0] idx_q;

  // MSB is consumed by the hunt state; start at the next bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= IDX_START;
    else if (step_i)  idx_q <= idx_q - 1'b1;
  end

  assign exp_bit_o = SIG[idx_q];
  assign last_o    = (idx_q == '0);

  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
  assert_single_ctl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));
endmodule

// File: rtl/dbg_mode_sel.sv
module dbg_mode_sel
  import dbg_sel_pkg::*;
#(
  parameter int unsigned RUN_LEN = RUN_MIN,
  parameter logic [SIG_W-1:0] SIG_VAL = SWITCH_SIG
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dio_i,
  output logic swd_mode_o,
  output logic sig_hit_o,
  output logic switch_done_o
);
  sel_state_e state_q, state_d;
  logic run_ok, near, exp_bit, last;
  logic load, step, clr, hit_d, done_d;
  logic mode_q, hit_q, done_q;

  dbg_run_cnt #(.RUN_MIN(RUN_LEN)) i_run_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (dio_i),
    .clr_i    (clr),
    .run_ok_o (run_ok),
    .near_o   (near)
  );

  dbg_sig_match #(.SIG_W(SIG_W), .SIG(SIG_VAL)) i_sig_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .exp_bit_o (exp_bit),
    .last_o    (last)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    clr     = 1'b0;
    hit_d   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        // first low after a satisfied run is signature bit MSB (0)
        if (!dio_i && run_ok) begin
          state_d = ST_SIG;
          load    = 1'b1;
        end
      end
      ST_SIG: begin
        if (dio_i != exp_bit) begin
          state_d = ST_HUNT;
        end else if (last) begin
          state_d = ST_TRAIL;
          clr     = 1'b1;
          hit_d   = 1'b1;
        end else begin
          step = 1'b1;
        end
      end
      ST_TRAIL: begin
        if (!dio_i) begin
          state_d = ST_HUNT;
        end else if (near) begin
          state_d = ST_SWD;
          done_d  = 1'b1;
        end
      end
      ST_SWD: ;
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      mode_q  <= 1'b0;
      hit_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_q | done_d;
      hit_q   <= hit_d;
      done_q  <= done_d;
    end
  end

  assign swd_mode_o    = mode_q;
  assign sig_hit_o     = hit_q;
  assign switch_done_o = done_q;

  assert_done_with_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_done_o |-> swd_mode_o && !$past(swd_mode_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_done_o |=> !switch_done_o);
  assert_rise_has_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swd_mode_o) |-> switch_done_o);
  assert_hit_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_hit_o |=> !sig_hit_o);
  assert_hit_needs_jtag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_hit_o |-> !swd_mode_o);
  assert_mode_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swd_mode_o |=> swd_mode_o && !sig_hit_o);
endmodule

// File: tb/test_dbg_mode_sel.sv
module test_dbg_mode_sel;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] SIG = 16'h79E7;

  typedef struct {
    logic  mode;
    logic  hit;
    logic  done;
    string tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dio_i = 1'b1;
  logic swd_mode_o, sig_hit_o, switch_done_o;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  int m_ones, m_st, m_idx;
  bit m_mode;

  dbg_mode_sel i_dbg_mode_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dio_i         (dio_i),
    .swd_mode_o    (swd_mode_o),
    .sig_hit_o     (sig_hit_o),
    .switch_done_o (switch_done_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic model_reset();
    m_ones = 0; m_st = 0; m_idx = 0; m_mode = 0;
  endtask

  // expected outputs after the edge that samples b
  task automatic model_step(input bit b, input string tag, output exp_t e);
    e.hit = 0; e.done = 0; e.tag = tag;
    case (m_st)
      0: if (!b && m_ones >= 51) begin m_st = 1; m_idx = 14; end
      1: if (b != SIG[m_idx]) m_st = 0;
         else if (m_idx == 0) begin m_st = 2; e.hit = 1; end
         else m_idx--;
      2: if (!b) m_st = 0;
         else if (m_ones == 50) begin m_st = 3; m_mode = 1; e.done = 1; end
      default: ;
    endcase
    if (e.hit || !b) m_ones = 0;
    else if (m_ones < 51) m_ones++;
    e.mode = m_mode;
  endtask

  task automatic send_bit(input bit b, input string tag);
    exp_t e;
    @(negedge clk_i);
    dio_i = b;
    model_step(b, tag, e);
    exp_q.push_back(e);
  endtask

  task automatic send_ones(input int n, input string tag);
    for (int i = 0; i < n; i++) send_bit(1'b1, tag);
  endtask

  task automatic send_sig(input int flip, input string tag);
    for (int i = 15; i >= 0; i--) send_bit(SIG[i] ^ (i == flip), tag);
  endtask

  task automatic check_now(input logic m, input logic h, input logic d, input string tag);
    checks++;
    if ({swd_mode_o, sig_hit_o, switch_done_o} !== {m, h, d}) begin
      errors++;
      $display("FAIL %s: got mode/hit/done=%b%b%b expected %b%b%b",
               tag, swd_mode_o, sig_hit_o, switch_done_o, m, h, d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_now(1'b0, 1'b0, 1'b0, "R1 R8 async reset");
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor: compare one expected item after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check_now(e.mode, e.hit, e.done, e.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    check_now(1'b0, 1'b0, 1'b0, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    send_ones(5, "R1 after reset");

    // full switch, then sticky behaviour
    send_ones(60, "R2 lead");
    send_sig(-1, "R3 R5 sig");
    send_ones(60, "R6 R7 trail");
    send_bit(1'b0, "R8 low after switch");
    send_ones(60, "R8 second lead");
    send_sig(-1, "R8 second sig");
    send_ones(60, "R8 second trail");
    do_reset();

    // 50-one lead is too short
    send_bit(1'b0, "R2 prefix");
    send_ones(50, "R2 short lead");
    send_sig(-1, "R2 sig after short lead");
    send_ones(60, "R2 trail after short lead");
    send_bit(1'b0, "R2 end");

    // exactly 51 ones, trail broken at 50
    send_ones(51, "R2 exact lead");
    send_sig(-1, "R3 R5 sig exact");
    send_ones(50, "R6 short trail");
    send_bit(1'b0, "R6 broken trail");
    send_ones(51, "R6 relead");
    send_sig(-1, "R5 resig");
    send_ones(51, "R7 exact trail");
    send_ones(3, "R8 hold");
    do_reset();

    // mismatches
    send_bit(1'b0, "R4 prefix");
    send_ones(55, "R4 lead");
    send_sig(8, "R4 mid mismatch");
    send_ones(60, "R4 trail after mismatch");
    send_bit(1'b0, "R4 end");
    send_ones(55, "R4 lead2");
    send_sig(0, "R4 last bit mismatch");
    send_ones(60, "R4 trail2");
    send_bit(1'b0, "R4 end2");
    send_ones(55, "R4 lead3");
    send_sig(15, "R4 first bit mismatch");
    send_ones(60, "R4 trail3");
    send_bit(1'b0, "R4 end3");
    send_ones(52, "R3 lead final");
    send_sig(-1, "R3 R5 sig final");
    send_ones(55, "R7 R8 trail final");

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule